// File: doc/BRIEF.md
# Five-Valued Netlist Settling Evaluator

This block holds a small gate netlist in a table of gate slots and evaluates it in discrete steps. Each net carries one of five values: tristate, low, high, contended or undetermined. A step request starts a series of sweeps. In each sweep, every gate output is computed from the net values stored at the start of that sweep. Each net is then rebuilt by joining the outputs of all gates that drive it with its own user driver. Sweeps repeat until one of them leaves every net unchanged. The block then reports completion and flags the result as settled.

A netlist with a feedback loop may never settle. To guard against this, the evaluator pauses after a fixed number of sweeps that each changed something. It then waits for a continue command, which allows another batch of sweeps, or an abort command. A single-sweep mode runs exactly one sweep for each request, which lets the surrounding logic trace an oscillation one sweep at a time.

Software-style access is limited to three write ports. One loads a gate slot. One sets a net's user driver to tristate, low or high. One forces a stored net value directly, bypassing resolution.

Top module: `net_settle_top`

## Requirements
- R1: Values use a 3-bit code: 0 tristate, 1 low, 2 high, 3 contended, 4 undetermined. After reset every net reads 4, `busy_o`, `paused_o` and `done_o` are 0, and every gate slot is empty.
- R2: Gate operation codes are: 0 empty (drives nothing), 1 NOT of input a, 2 AND, 3 OR, 4 XOR, 5 enable gate (a is the enable, b is the data). NOT inverts low and high; any other input gives undetermined.
- R3: AND gives low if either input is low and high only if both are high; OR gives high if either input is high and low only if both are low. All other input combinations give undetermined.
- R4: XOR gives the usual result when both inputs are low or high; any other input gives undetermined.
- R5: An enable gate gives tristate when the enable is low. With a high enable it passes low or high data and turns any other data into undetermined. An enable that is neither low nor high gives undetermined.
- R6: A net is the join of its user driver and all gate outputs aimed at it. Tristate is the identity of the join. Equal firm values stay unchanged. Low with high gives contended, and anything joined with contended gives contended. Undetermined with undetermined stays undetermined, and undetermined with a firm value gives contended.
- R7: A step runs sweeps until one sweep changes no net. It then raises `done_o` for one cycle with `settled_o` = 1.
- R8: After every 23 consecutive changing sweeps, the block holds `paused_o` high with all nets frozen. `cont_i` runs another batch of 23 sweeps. `abort_i` ends the step with `done_o` = 1 and `settled_o` = 0.
- R9: With `single_i` high at the step request, exactly one sweep runs. `done_o` follows, with `settled_o` = 1 only if that sweep changed nothing.
- R10: Each user driver takes its reset value from parameter `USR_INIT` (3 bits per net, default tristate). `usr_we_i` sets it later.
- R11: While idle, `force_i` overwrites the stored value of net `force_idx_i` with `force_val_i` on the next edge. The next sweep recomputes that net normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write a gate slot |
| cfg_idx_i | input | GATE_W | Gate slot index |
| cfg_op_i | input | 3 | Gate operation code |
| cfg_a_i | input | NET_W | Source net a |
| cfg_b_i | input | NET_W | Source net b |
| cfg_dst_i | input | NET_W | Destination net |
| usr_we_i | input | 1 | Write a user driver |
| usr_idx_i | input | NET_W | User driver net index |
| usr_val_i | input | 3 | User driver value (0, 1 or 2) |
| force_i | input | 1 | Force a stored net value (idle only) |
| force_idx_i | input | NET_W | Forced net index |
| force_val_i | input | 3 | Forced value |
| step_i | input | 1 | Start a step (idle only) |
| single_i | input | 1 | Single-sweep mode, sampled with step_i |
| cont_i | input | 1 | Continue from pause |
| abort_i | input | 1 | Abort from pause |
| net_o | output | NUM_NETS*3 | Stored net values, net i at bits [3i+2:3i] |
| busy_o | output | 1 | Step in progress or paused |
| paused_o | output | 1 | Oscillation guard pause |
| done_o | output | 1 | One-cycle step completion pulse |
| settled_o | output | 1 | Qualifies done_o: last sweep changed nothing |

## Verification
The bench uses the default 8 nets, 8 gate slots and a pause interval of 23. It overrides `USR_INIT` so that net 1 starts with a high user driver, which exercises the initial-driver path. With 8 nets, a single netlist covers every gate type and a net with two drivers. The bench sweeps that netlist over all nine tristate/low/high input pairs. A user driver on a gate-driven net produces both contended and undetermined inputs. The bench then re-aims one slot as a self-inverting loop. That loop never settles, so two full pause intervals and an abort fall within a few dozen cycles.

// File: rtl/net_settle_pkg.sv
package net_settle_pkg;
  typedef enum logic [2:0] {
    V_Z   = 3'd0,
    V_LO  = 3'd1,
    V_HI  = 3'd2,
    V_CON = 3'd3,
    V_UND = 3'd4
  } val_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_NOT  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_EN   = 3'd5
  } op_e;

  function automatic logic is_firm(val_e v);
    return (v == V_LO) || (v == V_HI);
  endfunction

  function automatic val_e gate_eval(op_e op, val_e a, val_e b);
    val_e r;
    r = V_UND;
    unique case (op)
      OP_NOT: if (is_firm(a)) r = (a == V_LO) ? V_HI : V_LO;
      OP_AND: begin
        if (a == V_LO || b == V_LO) r = V_LO;
        else if (a == V_HI && b == V_HI) r = V_HI;
      end
      OP_OR: begin
        if (a == V_HI || b == V_HI) r = V_HI;
        else if (a == V_LO && b == V_LO) r = V_LO;
      end
      OP_XOR: if (is_firm(a) && is_firm(b)) r = (a != b) ? V_HI : V_LO;
      OP_EN: begin
        if (a == V_LO) r = V_Z;
        else if (a == V_HI && is_firm(b)) r = b;
      end
      default: r = V_Z;
    endcase
    return r;
  endfunction

  function automatic val_e wire_join(val_e a, val_e b);
    if (a == V_Z) return b;
    if (b == V_Z) return a;
    if (a == V_CON || b == V_CON) return V_CON;
    if (a == V_UND && b == V_UND) return V_UND;
    if (a == V_UND || b == V_UND) return V_CON;
    if (a == b) return a;
    return V_CON;
  endfunction
endpackage

// File: rtl/net_gate_table.sv
module net_gate_table
  import net_settle_pkg::*;
#(
  parameter int NUM_NETS  = 8,
  parameter int NUM_GATES = 8,
  localparam int NET_W  = $clog2(NUM_NETS),
  localparam int GATE_W = $clog2(NUM_GATES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [GATE_W-1:0]            idx_i,
  input  logic [2:0]                   op_i,
  input  logic [NET_W-1:0]             a_i,
  input  logic [NET_W-1:0]             b_i,
  input  logic [NET_W-1:0]             dst_i,
  input  val_e [NUM_NETS-1:0]          nets_i,
  output val_e [NUM_GATES-1:0]         gout_o,
  output logic [NUM_GATES-1:0][NET_W-1:0] gdst_o,
  output logic [NUM_GATES-1:0]         gact_o
);
  op_e              op_q  [NUM_GATES];
  logic [NET_W-1:0] a_q   [NUM_GATES];
  logic [NET_W-1:0] b_q   [NUM_GATES];
  logic [NET_W-1:0] dst_q [NUM_GATES];

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        op_q[g]  <= OP_NONE;
        a_q[g]   <= '0;
        b_q[g]   <= '0;
        dst_q[g] <= '0;
      end else if (we_i && idx_i == GATE_W'(g)) begin
        op_q[g]  <= op_e'(op_i);
        a_q[g]   <= a_i;
        b_q[g]   <= b_i;
        dst_q[g] <= dst_i;
      end
    end

    assign gout_o[g] = gate_eval(op_q[g], nets_i[a_q[g]], nets_i[b_q[g]]);
    assign gdst_o[g] = dst_q[g];
    assign gact_o[g] = (op_q[g] != OP_NONE);
  end
endmodule

// File: rtl/net_resolver.sv
module net_resolver
  import net_settle_pkg::*;
#(
  parameter int NUM_NETS  = 8,
  parameter int NUM_GATES = 8,
  localparam int NET_W = $clog2(NUM_NETS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  val_e [NUM_NETS-1:0]             nets_i,
  input  val_e [NUM_NETS-1:0]             usr_i,
  input  val_e [NUM_GATES-1:0]            gout_i,
  input  logic [NUM_GATES-1:0][NET_W-1:0] gdst_i,
  input  logic [NUM_GATES-1:0]            gact_i,
  output val_e [NUM_NETS-1:0]             res_o,
  output logic                            changed_o
);
  always_comb begin
    for (int n = 0; n < NUM_NETS; n++) begin
      val_e acc;
      acc = usr_i[n];
      for (int g = 0; g < NUM_GATES; g++)
        if (gact_i[g] && gdst_i[g] == NET_W'(n)) acc = wire_join(acc, gout_i[g]);
      res_o[n] = acc;
    end
  end

  assign changed_o = (res_o != nets_i);

  // R6: a net with no active gate driver takes exactly its user driver
  for (genvar n = 0; n < NUM_NETS; n++) begin : g_chk
    logic driven;
    always_comb begin
      driven = 1'b0;
      for (int g = 0; g < NUM_GATES; g++)
        if (gact_i[g] && gdst_i[g] == NET_W'(n)) driven = 1'b1;
    end
    a_r6_undriven_follows_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !driven |-> res_o[n] == usr_i[n]);
  end
endmodule

// File: rtl/net_sweep_ctrl.sv
module net_sweep_ctrl #(
  parameter int PAUSE_SWEEPS = 23,
  localparam int CNT_W = $clog2(PAUSE_SWEEPS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic single_i,
  input  logic cont_i,
  input  logic abort_i,
  input  logic changed_i,
  output logic sweep_o,
  output logic idle_o,
  output logic paused_o,
  output logic done_o,
  output logic settled_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAUSE} st_e;

  st_e             st_q;
  logic            single_q, done_q, settled_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      single_q  <= 1'b0;
      done_q    <= 1'b0;
      settled_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      done_q    <= 1'b0;
      settled_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (step_i) begin
          st_q     <= S_RUN;
          single_q <= single_i;
          cnt_q    <= '0;
        end
        S_RUN: begin
          if (!changed_i || single_q) begin
            st_q      <= S_IDLE;
            done_q    <= 1'b1;
            settled_q <= !changed_i;
          end else if (cnt_q == CNT_W'(PAUSE_SWEEPS - 1)) begin
            st_q  <= S_PAUSE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_PAUSE: begin
          if (abort_i) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else if (cont_i) begin
            st_q <= S_RUN;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sweep_o   = (st_q == S_RUN);
  assign idle_o    = (st_q == S_IDLE);
  assign paused_o  = (st_q == S_PAUSE);
  assign done_o    = done_q;
  assign settled_o = settled_q;

  a_r7_settled_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled_o |-> done_o);
  a_r9_single_one_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_o && single_q) |=> idle_o);
  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(PAUSE_SWEEPS));
  a_r8_abort_unsettled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && abort_i) |=> (done_o && !settled_o));
endmodule

// File: rtl/net_settle_top.sv
module net_settle_top
  import net_settle_pkg::*;
#(
  parameter int NUM_NETS     = 8,
  parameter int NUM_GATES    = 8,
  parameter int PAUSE_SWEEPS = 23,
  parameter logic [NUM_NETS*3-1:0] USR_INIT = '0,
  localparam int NET_W  = $clog2(NUM_NETS),
  localparam int GATE_W = $clog2(NUM_GATES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [GATE_W-1:0]     cfg_idx_i,
  input  logic [2:0]            cfg_op_i,
  input  logic [NET_W-1:0]      cfg_a_i,
  input  logic [NET_W-1:0]      cfg_b_i,
  input  logic [NET_W-1:0]      cfg_dst_i,
  input  logic                  usr_we_i,
  input  logic [NET_W-1:0]      usr_idx_i,
  input  logic [2:0]            usr_val_i,
  input  logic                  force_i,
  input  logic [NET_W-1:0]      force_idx_i,
  input  logic [2:0]            force_val_i,
  input  logic                  step_i,
  input  logic                  single_i,
  input  logic                  cont_i,
  input  logic                  abort_i,
  output logic [NUM_NETS*3-1:0] net_o,
  output logic                  busy_o,
  output logic                  paused_o,
  output logic                  done_o,
  output logic                  settled_o
);
  val_e [NUM_NETS-1:0]             net_q, usr_q, res;
  val_e [NUM_GATES-1:0]            gout;
  logic [NUM_GATES-1:0][NET_W-1:0] gdst;
  logic [NUM_GATES-1:0]            gact;
  logic sweep, idle, changed;

  net_gate_table #(.NUM_NETS(NUM_NETS), .NUM_GATES(NUM_GATES)) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .op_i(cfg_op_i),
    .a_i(cfg_a_i), .b_i(cfg_b_i), .dst_i(cfg_dst_i),
    .nets_i(net_q), .gout_o(gout), .gdst_o(gdst), .gact_o(gact)
  );

  net_resolver #(.NUM_NETS(NUM_NETS), .NUM_GATES(NUM_GATES)) u_res (
    .clk_i, .rst_ni,
    .nets_i(net_q), .usr_i(usr_q), .gout_i(gout), .gdst_i(gdst), .gact_i(gact),
    .res_o(res), .changed_o(changed)
  );

  net_sweep_ctrl #(.PAUSE_SWEEPS(PAUSE_SWEEPS)) u_ctrl (
    .clk_i, .rst_ni,
    .step_i, .single_i, .cont_i, .abort_i, .changed_i(changed),
    .sweep_o(sweep), .idle_o(idle), .paused_o, .done_o, .settled_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_NETS; n++) begin
        net_q[n] <= V_UND;
        usr_q[n] <= val_e'(USR_INIT[n*3 +: 3]);
      end
    end else begin
      if (usr_we_i) usr_q[usr_idx_i] <= val_e'(usr_val_i);
      if (sweep) net_q <= res;
      else if (idle && force_i) net_q[force_idx_i] <= val_e'(force_val_i);
    end
  end

  assign net_o  = net_q;
  assign busy_o = !idle;

  a_r8_frozen_in_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |=> $stable(net_q));
  a_r11_force_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && force_i) |=> net_q[$past(force_idx_i)] == val_e'($past(force_val_i)));
  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !force_i) |=> $stable(net_q));
endmodule

// File: tb/sim_net_settle_top.sv
module sim_net_settle_top;
  localparam int CLK_PERIOD = 10;
  localparam int NN = 8;
  localparam int NG = 8;
  localparam int WDOG = 100000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 0, usr_we = 0, force_en = 0, step = 0, single = 0, cont = 0, abort_c = 0;
  logic [2:0] cfg_idx = 0, cfg_op = 0, cfg_a = 0, cfg_b = 0, cfg_dst = 0;
  logic [2:0] usr_idx = 0, usr_val = 0, force_idx = 0, force_val = 0;
  logic [NN*3-1:0] net;
  logic busy, paused, done, settled;

  always #(CLK_PERIOD/2) clk = ~clk;

  net_settle_top #(.NUM_NETS(NN), .NUM_GATES(NG), .PAUSE_SWEEPS(23), .USR_INIT(24'h000010)) u0 (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_op_i(cfg_op),
    .cfg_a_i(cfg_a), .cfg_b_i(cfg_b), .cfg_dst_i(cfg_dst),
    .usr_we_i(usr_we), .usr_idx_i(usr_idx), .usr_val_i(usr_val),
    .force_i(force_en), .force_idx_i(force_idx), .force_val_i(force_val),
    .step_i(step), .single_i(single), .cont_i(cont), .abort_i(abort_c),
    .net_o(net), .busy_o(busy), .paused_o(paused), .done_o(done), .settled_o(settled)
  );

  typedef struct {string req; int kind; int idx; int val;} exp_t; // kind 0: net, 1: settled flag
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int netv(int i);
    return int'(net[i*3 +: 3]);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_ni && done) begin
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.kind == 1) check(e.req, "settled", int'(settled), e.val);
        else check(e.req, $sformatf("net%0d", e.idx), netv(e.idx), e.val);
      end
    end
  end

  // reference value model (0 Z, 1 LO, 2 HI, 3 CON, 4 UND)
  function automatic int m_not(int a);
    case (a) 1: return 2; 2: return 1; default: return 4; endcase
  endfunction
  function automatic int m_and(int a, int b);
    if (a == 1 || b == 1) return 1;
    return (a == 2 && b == 2) ? 2 : 4;
  endfunction
  function automatic int m_or(int a, int b);
    if (a == 2 || b == 2) return 2;
    return (a == 1 && b == 1) ? 1 : 4;
  endfunction
  function automatic int m_xor(int a, int b);
    if ((a == 1 || a == 2) && (b == 1 || b == 2)) return (a == b) ? 1 : 2;
    return 4;
  endfunction
  function automatic int m_en(int e, int d);
    if (e == 1) return 0;
    if (e == 2 && (d == 1 || d == 2)) return d;
    return 4;
  endfunction
  function automatic int m_join(int a, int b);
    if (a == 0) return b;
    if (b == 0) return a;
    if (a == 3 || b == 3) return 3;
    if (a == 4 && b == 4) return 4;
    if (a == 4 || b == 4) return 3;
    return (a == b) ? a : 3;
  endfunction

  task automatic push(string req, int kind, int idx, int val);
    exp_t e;
    e.req = req; e.kind = kind; e.idx = idx; e.val = val;
    exp_q.push_back(e);
  endtask

  // expected settled nets of the truth netlist for user drivers ua, ub, u2
  task automatic push_model(string req, int ua, int ub, int u2);
    int n0, n1, n2;
    n0 = ua; n1 = ub;
    n2 = m_join(u2, m_not(n0));
    push(req, 0, 0, n0);
    push(req, 0, 1, n1);
    push("R6", 0, 2, n2);
    push("R3", 0, 3, m_and(n0, n1));
    push("R3", 0, 4, m_or(n0, n1));
    push("R4", 0, 5, m_xor(n0, n1));
    push("R5", 0, 6, m_en(n1, n0));
    push("R2", 0, 7, m_not(n2));
    push("R7", 1, 0, 1);
  endtask

  task automatic cfg(int g, int op, int a, int b, int d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(g); cfg_op = 3'(op); cfg_a = 3'(a); cfg_b = 3'(b); cfg_dst = 3'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_usr(int i, int v);
    @(negedge clk);
    usr_we = 1; usr_idx = 3'(i); usr_val = 3'(v);
    @(negedge clk);
    usr_we = 0;
  endtask

  task automatic run_step(bit s);
    @(negedge clk);
    step = 1; single = s;
    @(negedge clk);
    step = 0; single = 0;
    while (!done && cyc < WDOG) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_paused(bit lvl);
    while (paused != lvl && cyc < WDOG) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NN; i++) check("R1", $sformatf("reset net%0d", i), netv(i), 4);
    check("R1", "busy", int'(busy), 0);
    check("R1", "paused", int'(paused), 0);
    check("R1", "done", int'(done), 0);
    rst_ni = 1;
    // R1: empty slots drive nothing, so a step leaves user driver values only
    push("R10", 0, 1, 2);
    push("R1", 0, 3, 0);
    run_step(0);

    cfg(0, 1, 0, 0, 2);  // n2 = NOT n0
    cfg(1, 2, 0, 1, 3);  // n3 = n0 AND n1
    cfg(2, 3, 0, 1, 4);  // n4 = n0 OR n1
    cfg(3, 4, 0, 1, 5);  // n5 = n0 XOR n1
    cfg(4, 5, 1, 0, 6);  // n6 = enable n1, data n0
    cfg(5, 1, 2, 0, 7);  // n7 = NOT n2

    // R10: net1 user driver starts high from USR_INIT
    push_model("R10", 0, 2, 0);
    run_step(0);

    // R2-R5: all tristate/low/high input pairs
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) begin
        set_usr(0, a);
        set_usr(1, b);
        push_model("R3", a, b, 0);
        run_step(0);
      end

    // R6: user driver joined with gate output on n2
    set_usr(0, 1); set_usr(1, 2); set_usr(2, 1);
    push_model("R6", 1, 2, 1);      // HI joined LO -> CON, NOT CON -> UND
    run_step(0);
    set_usr(2, 2);
    push_model("R6", 1, 2, 2);      // HI joined HI -> HI
    run_step(0);
    set_usr(0, 0);
    push_model("R6", 0, 2, 2);      // UND joined HI -> CON
    run_step(0);
    set_usr(2, 0);
    push_model("R6", 0, 2, 0);      // UND joined Z -> UND
    run_step(0);

    // R9: single sweeps, n0 updates first, n2 one sweep later
    set_usr(0, 1);
    push("R9", 0, 0, 1);
    push("R9", 0, 2, 4);
    push("R9", 1, 0, 0);
    run_step(1);
    push("R9", 0, 2, 2);
    push("R9", 1, 0, 0);
    run_step(1);
    run_step(0);
    push("R9", 0, 2, 2);
    push("R9", 1, 0, 1);
    run_step(1);

    // R11: force overrides, next step restores
    @(negedge clk);
    force_en = 1; force_idx = 3; force_val = 2;
    @(negedge clk);
    force_en = 0;
    check("R11", "forced net3", netv(3), 2);
    push_model("R11", 1, 2, 0);
    run_step(0);

    // R8: self-inverting loop on n7
    cfg(5, 1, 7, 0, 7);
    @(negedge clk);
    force_en = 1; force_idx = 7; force_val = 1;
    @(negedge clk);
    force_en = 0;
    push("R8", 0, 7, 1);
    push("R8", 1, 0, 0);
    @(negedge clk);
    step = 1;
    @(negedge clk);
    step = 0;
    wait_paused(1);
    check("R8", "paused after 23", int'(paused), 1);
    check("R8", "n7 after 23", netv(7), 2);
    repeat (3) @(negedge clk);
    check("R8", "n7 frozen", netv(7), 2);
    check("R8", "still paused", int'(paused), 1);
    cont = 1;
    @(negedge clk);
    cont = 0;
    wait_paused(0);
    wait_paused(1);
    check("R8", "n7 after 46", netv(7), 1);
    abort_c = 1;
    @(negedge clk);
    abort_c = 0;
    @(negedge clk);
    check("R8", "idle after abort", int'(busy), 0);

    if (cyc >= WDOG) check("WDOG", "watchdog", 1, 0);
    check("R7", "queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * (WDOG + 10));
    n_bad++;
    $display("FAIL WDOG watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end
endmodule